// File: doc/BRIEF.md
# Half-Bridge Leg Interlock and Deadtime Generator

This block drives one half-bridge leg. It takes a high-side command and a low-side command, both active low, and an active-high enable. From them it produces two gate-drive requests, one for the upper switch and one for the lower switch. A chip places three copies of it for a three-phase inverter. Fault and undervoltage logic share one force-off input that reaches every copy.

Each input first passes through a deglitch filter. The two commands use a short filter, and the enable uses a longer one. The filtered inputs are then decoded. When both commands are active together the leg is interlocked and both gates stay off. A single shared deadtime timer makes sure that when one gate turns off, its partner cannot turn on until a minimum number of cycles has passed. This deadtime is only a floor. If the controller already leaves a longer gap between its commands, the outputs follow that gap without extra delay. All timing is given as nanosecond parameters and converted into clock cycles.

Top module: `hb_leg_deadtime`

## Requirements
- R1: When the filtered enable (`en_i`, 1 = enabled) is low, both gate outputs are low, whatever the command inputs are.
- R2: With enable high, a low-side command alone (`ls_cmd_ni` = 0, `hs_cmd_ni` = 1) drives only `ls_gate_o` high. A high-side command alone (`hs_cmd_ni` = 0, `ls_cmd_ni` = 1) drives only `hs_gate_o` high. With no command active, both outputs are low.
- R3: When both commands are active (both inputs 0), both outputs are held low.
- R4: `hs_gate_o` and `ls_gate_o` are never high in the same cycle.
- R5: After either output falls, its partner stays low for at least DEAD_CYC cycles (DEAD_NS rounded up to whole clock periods).
- R6: When the commands swap in the same cycle, the gap is exactly DEAD_CYC cycles. This holds in both directions, low-to-high and high-to-low.
- R7: When the command for the new side arrives G ≥ DEAD_CYC cycles after the old side's command is released, the output gap is exactly G cycles.
- R8: A command level must stay stable for CMD_CYC cycles before it is accepted. The output then changes on the clock edge CMD_CYC+1 after the input change. Shorter pulses have no effect.
- R9: The enable must stay stable for EN_CYC cycles before it is accepted. The output then changes on the edge EN_CYC+1 after the change. Shorter enable drops have no effect.
- R10: `force_off_i` = 1 forces both outputs low from the next clock edge. After it is released, the still-commanded side turns back on at the next edge.
- R11: A turn-on request that arrives while the deadtime timer is running is held. It takes effect when the timer expires, but only if the request is still present at that point. A request that is withdrawn earlier never turns its output on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Leg enable, active high |
| hs_cmd_ni | input | 1 | High-side command, active low |
| ls_cmd_ni | input | 1 | Low-side command, active low |
| force_off_i | input | 1 | Fault/undervoltage force-off, active high |
| hs_gate_o | output | 1 | High-side gate request |
| ls_gate_o | output | 1 | Low-side gate request |

## Verification
The command handover is tested with four edge offsets:
- Overlapping commands show that the interlock turns the old side off early, and that the deadtime is still counted from that turn-off.
- Synchronous swaps in both directions measure the bare deadtime and show whether it matches.
- A gap inside the deadtime shows that the internal floor takes over.
- A gap outside the deadtime shows that the controller's own gap passes through unchanged.

Three more cases target specific behaviour:
- A withdrawn request during the timer separates "held and still honoured" from "latched regardless".
- Short pulses on the commands and on the enable separate proper filtering from plain delay.
- Pulses of force-off show both the immediate turn-off and the release of the still-commanded side.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_pair_t;

  function automatic int ns_to_cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
  parameter int   STABLE_CYC = 8,
  parameter logic RST_VAL    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= RST_VAL;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/hb_dead_core.sv
module hb_dead_core
  import hb_dt_pkg::*;
#(
  parameter int DEAD_CYC = 60
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  leg_pair_t want_i,
  output leg_pair_t gate_o
);
  localparam int CW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;

  leg_pair_t     gate_q, gate_d, blk_q, blk_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy, off_hs, off_ls, ok_hs, ok_ls;

  always_comb begin
    busy   = (cnt_q != '0);
    off_hs = gate_q.hs & ~want_i.hs;
    off_ls = gate_q.ls & ~want_i.ls;
    // a side may rise only when its partner is already off and no partner turn-off is still timing
    ok_hs  = want_i.hs & ~want_i.ls & ~gate_q.ls & ~(busy & blk_q.hs);
    ok_ls  = want_i.ls & ~want_i.hs & ~gate_q.hs & ~(busy & blk_q.ls);
    gate_d.hs = want_i.hs & ~want_i.ls & (gate_q.hs | ok_hs);
    gate_d.ls = want_i.ls & ~want_i.hs & (gate_q.ls | ok_ls);

    cnt_d = cnt_q;
    blk_d = blk_q;
    if (off_hs | off_ls) begin
      cnt_d    = CW'(DEAD_CYC - 1);
      blk_d    = busy ? blk_q : '0;
      blk_d.ls = blk_d.ls | off_hs;
      blk_d.hs = blk_d.hs | off_ls;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      blk_q  <= '0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      blk_q  <= blk_d;
      cnt_q  <= cnt_d;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
  import hb_dt_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int CMD_FILT_NS = 40,
  parameter int EN_FILT_NS  = 300,
  parameter int DEAD_NS     = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hs_cmd_ni,
  input  logic ls_cmd_ni,
  input  logic force_off_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  localparam int CMD_CYC  = ns_to_cyc(CMD_FILT_NS, CLK_NS);
  localparam int EN_CYC   = ns_to_cyc(EN_FILT_NS, CLK_NS);
  localparam int DEAD_CYC = ns_to_cyc(DEAD_NS, CLK_NS);

  logic [1:0] cmd_raw_n, cmd_flt_n;
  logic       en_flt;
  leg_pair_t  want, gate;

  assign cmd_raw_n = {hs_cmd_ni, ls_cmd_ni};

  for (genvar g = 0; g < 2; g++) begin : g_cmd_flt
    hb_deglitch #(.STABLE_CYC(CMD_CYC), .RST_VAL(1'b1)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cmd_raw_n[g]),
      .q_o   (cmd_flt_n[g])
    );
  end

  hb_deglitch #(.STABLE_CYC(EN_CYC), .RST_VAL(1'b0)) u_en_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_flt)
  );

  always_comb begin
    want.hs = en_flt & ~force_off_i & ~cmd_flt_n[1] & cmd_flt_n[0];
    want.ls = en_flt & ~force_off_i & ~cmd_flt_n[0] & cmd_flt_n[1];
  end

  hb_dead_core #(.DEAD_CYC(DEAD_CYC)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .want_i(want),
    .gate_o(gate)
  );

  assign hs_gate_o = gate.hs;
  assign ls_gate_o = gate.ls;
endmodule

// File: rtl/hb_leg_deadtime_chk.sv
module hb_leg_deadtime_chk
  import hb_dt_pkg::*;
#(
  parameter int CLK_NS      = 5,
  parameter int CMD_FILT_NS = 40,
  parameter int EN_FILT_NS  = 300,
  parameter int DEAD_NS     = 300
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic hs_cmd_ni,
  input logic ls_cmd_ni,
  input logic force_off_i,
  input logic hs_gate_o,
  input logic ls_gate_o
);
  localparam int CMD_CYC  = ns_to_cyc(CMD_FILT_NS, CLK_NS);
  localparam int EN_CYC   = ns_to_cyc(EN_FILT_NS, CLK_NS);
  localparam int DEAD_CYC = ns_to_cyc(DEAD_NS, CLK_NS);
  localparam int SW       = $clog2(EN_CYC + DEAD_CYC + CMD_CYC + 8) + 1;
  localparam logic [SW-1:0] SAT = '1;

  logic [SW-1:0] since_hs_q, since_ls_q, en_low_q, both_q;
  logic          hs_prev_q, ls_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_hs_q <= SAT;
      since_ls_q <= SAT;
      en_low_q   <= '0;
      both_q     <= '0;
      hs_prev_q  <= 1'b0;
      ls_prev_q  <= 1'b0;
    end else begin
      hs_prev_q  <= hs_gate_o;
      ls_prev_q  <= ls_gate_o;
      since_hs_q <= (hs_prev_q & ~hs_gate_o) ? SW'(1) : (since_hs_q == SAT ? SAT : since_hs_q + 1'b1);
      since_ls_q <= (ls_prev_q & ~ls_gate_o) ? SW'(1) : (since_ls_q == SAT ? SAT : since_ls_q + 1'b1);
      en_low_q   <= en_i ? '0 : (en_low_q == SAT ? SAT : en_low_q + 1'b1);
      both_q     <= (hs_cmd_ni | ls_cmd_ni) ? '0 : (both_q == SAT ? SAT : both_q + 1'b1);
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o)); // R4
  AST_HS_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_gate_o) |-> (since_ls_q >= SW'(DEAD_CYC))); // R5
  AST_LS_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_o) |-> (since_hs_q >= SW'(DEAD_CYC))); // R5
  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!hs_gate_o && !ls_gate_o)); // R10
  AST_EN_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_low_q >= SW'(EN_CYC + 2)) |-> (!hs_gate_o && !ls_gate_o)); // R1
  AST_INTERLOCK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_q >= SW'(CMD_CYC + 2)) |-> (!hs_gate_o && !ls_gate_o)); // R3
endmodule

bind hb_leg_deadtime hb_leg_deadtime_chk #(
  .CLK_NS(CLK_NS), .CMD_FILT_NS(CMD_FILT_NS), .EN_FILT_NS(EN_FILT_NS), .DEAD_NS(DEAD_NS)
) u_chk (.*);

// File: tb/tb_hb_leg_deadtime.sv
module tb_hb_leg_deadtime;
  localparam int CMD_CYC  = 8;
  localparam int EN_CYC   = 60;
  localparam int DEAD_CYC = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, hs_n = 1'b1, ls_n = 1'b1, force_off = 1'b0;
  logic hs_g, ls_g;

  int errors = 0, checks = 0, cyc = 0;
  int t_hs_rise = -1, t_ls_rise = -1, t_hs_fall = -1, t_ls_fall = -1;
  int hs_rises = 0, ls_falls = 0, overlap_seen = 0;
  logic hs_p = 1'b0, ls_p = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_leg_deadtime dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hs_cmd_ni(hs_n), .ls_cmd_ni(ls_n),
    .force_off_i(force_off), .hs_gate_o(hs_g), .ls_gate_o(ls_g)
  );

  always @(negedge clk) begin
    cyc++;
    if (hs_g && !hs_p) begin t_hs_rise = cyc; hs_rises++; end
    if (!hs_g && hs_p) t_hs_fall = cyc;
    if (ls_g && !ls_p) t_ls_rise = cyc;
    if (!ls_g && ls_p) begin t_ls_fall = cyc; ls_falls++; end
    if (hs_g && ls_g) overlap_seen++;
    hs_p = hs_g;
    ls_p = ls_g;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_enable;
    check(!hs_g && !ls_g, "R1 reset state", {hs_g, ls_g}, 0);
    @(negedge clk); rst_n = 1'b1;
    ls_n = 1'b0;
    wait_cyc(150);
    check(!hs_g && !ls_g, "R1 enable low blocks command", {hs_g, ls_g}, 0);
    en = 1'b1;
    wait_cyc(EN_CYC);
    check(!ls_g, "R9 enable not yet accepted", ls_g, 0);
    wait_cyc(1);
    check(ls_g && !hs_g, "R9 enable latency", {hs_g, ls_g}, 1);
  endtask

  task automatic t_enable_glitch;
    int f0 = ls_falls;
    en = 1'b0;
    wait_cyc(EN_CYC / 2);
    en = 1'b1;
    wait_cyc(100);
    check(ls_g && ls_falls == f0, "R9 short enable drop ignored", ls_falls - f0, 0);
  endtask

  task automatic t_truth;
    ls_n = 1'b1;
    wait_cyc(CMD_CYC);
    check(ls_g, "R8 release not yet accepted", ls_g, 1);
    wait_cyc(1);
    check(!ls_g && !hs_g, "R2 no command both off", {hs_g, ls_g}, 0);
    hs_n = 1'b0;
    wait_cyc(100);
    check(hs_g && !ls_g, "R2 high side alone", {hs_g, ls_g}, 2);
    ls_n = 1'b0;
    wait_cyc(30);
    check(!hs_g && !ls_g, "R3 both active interlocked", {hs_g, ls_g}, 0);
    ls_n = 1'b1;
    hs_n = 1'b1;
    wait_cyc(100);
  endtask

  task automatic t_cmd_glitch;
    int r0 = hs_rises;
    hs_n = 1'b0;
    wait_cyc(CMD_CYC - 3);
    hs_n = 1'b1;
    wait_cyc(40);
    check(hs_rises == r0 && !hs_g, "R8 short command pulse ignored", hs_rises - r0, 0);
  endtask

  task automatic t_force;
    hs_n = 1'b0;
    wait_cyc(100);
    force_off = 1'b1;
    wait_cyc(1);
    check(!hs_g && !ls_g, "R10 force-off next edge", {hs_g, ls_g}, 0);
    wait_cyc(5);
    force_off = 1'b0;
    wait_cyc(1);
    check(hs_g, "R10 release restores commanded side", hs_g, 1);
  endtask

  // start with low side on; G = command gap, ovl = high side asserted G cycles before low releases
  task automatic t_sweep(int g, bit ovl, int exp, string req);
    hs_n = 1'b1; ls_n = 1'b0;
    wait_cyc(200);
    if (ovl) begin
      hs_n = 1'b0; wait_cyc(g); ls_n = 1'b1;
    end else begin
      ls_n = 1'b1; wait_cyc(g); hs_n = 1'b0;
    end
    wait_cyc(200);
    check(hs_g && !ls_g && (t_hs_rise - t_ls_fall) == exp, req, t_hs_rise - t_ls_fall, exp);
  endtask

  task automatic t_reverse_sync;
    hs_n = 1'b0; ls_n = 1'b1;
    wait_cyc(200);
    hs_n = 1'b1; ls_n = 1'b0;
    wait_cyc(200);
    check(ls_g && (t_ls_rise - t_hs_fall) == DEAD_CYC, "R6 high-to-low gap matches",
          t_ls_rise - t_hs_fall, DEAD_CYC);
  endtask

  task automatic t_withdraw;
    int r0;
    hs_n = 1'b1; ls_n = 1'b0;
    wait_cyc(200);
    r0 = hs_rises;
    ls_n = 1'b1; hs_n = 1'b0;
    wait_cyc(20);
    hs_n = 1'b1;
    wait_cyc(200);
    check(hs_rises == r0 && !hs_g && !ls_g, "R11 withdrawn request dropped", hs_rises - r0, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset_enable();
    t_enable_glitch();
    t_truth();
    t_cmd_glitch();
    t_force();
    t_sweep(10, 1'b1, DEAD_CYC, "R5 overlapping commands");
    t_sweep(0, 1'b0, DEAD_CYC, "R6 R11 synchronous swap");
    t_sweep(20, 1'b0, DEAD_CYC, "R5 gap inside deadtime");
    t_sweep(100, 1'b0, 100, "R7 gap outside deadtime");
    t_reverse_sync();
    t_withdraw();
    en = 1'b0; hs_n = 1'b0;
    wait_cyc(150);
    check(!hs_g && !ls_g, "R1 enable dropped", {hs_g, ls_g}, 0);
    check(overlap_seen == 0, "R4 never both high", overlap_seen, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule